// File: doc/BRIEF.md
# Majority-Vote Asynchronous Serial Receiver

This block receives asynchronous serial characters on a single line. A 16x oversampling tick paces it. A falling edge on an idle-high line starts a character. The block confirms that edge with extra early samples. It then shifts in 8 or 9 data bits, least significant bit first, and checks the stop bit. Each data bit and the stop bit are sampled three times around mid-bit, and a two-out-of-three vote decides the value. Any disagreement between samples is reported as noise.

The completed character is placed in a holding register with an optional ninth bit. Five sticky status flags describe each character: receive-full, idle line, overrun, noise and framing error. A single clear pulse drops all five, which stands for a status read followed by a data read. A sleep mode lets the receiver ignore traffic that is not meant for it. The receiver wakes either on an idle line or on a character that carries an address mark.

Top module: `noise_vote_rx`

## Requirements
- R1: In 8-bit mode (`nineBitMode`=0) the receiver assembles 8 data bits, least significant bit first, between a start bit and a stop bit. It then presents them on `rxData` and sets `rxFull`.
- R2: In 9-bit mode (`nineBitMode`=1) the receiver assembles 9 data bits. The first 8 go to `rxData` and the ninth goes to `rxBit9`. In 8-bit mode `rxBit9` reads 0.
- R3: Each data bit is sampled on oversampling phases 8, 9 and 10, counting the start edge as phase 1. The value taken is the majority of the three samples, so two flipped samples flip the bit.
- R4: `noiseFlag` is set together with `rxFull` when any vote within the character sees samples that are not all equal. A single flipped sample still yields the correct data.
- R5: After the start edge the line is sampled on phases 3, 5 and 7. If most of those samples are 1 the start is discarded and no character is received. If only one of them is 1 the character is accepted and `noiseFlag` is set.
- R6: `frameErr` is set when the stop-bit vote gives 0. The data is still loaded and `rxFull` is still set.
- R7: A character that completes while `rxFull` is 1 sets `overrunFlag` and leaves `rxData` and `rxBit9` unchanged.
- R8: `idleFlag` is set after one full character time of 1s on the line: 160 ticks in 8-bit mode, 176 in 9-bit mode. It can be set only once per received character, and never before the first character after reset.
- R9: A one-cycle `clearFlags` pulse clears `rxFull`, `idleFlag`, `overrunFlag`, `noiseFlag` and `frameErr`. A flag being set in the same cycle takes priority.
- R10: `sleepSet` puts the receiver asleep (`asleep`=1). While asleep, characters and idle periods set none of the five flags.
- R11: With `wakeByAddr`=0, an idle period of one character time while asleep clears `asleep` without setting `idleFlag`.
- R12: With `wakeByAddr`=1, a character received while asleep whose most significant data bit is 1 clears `asleep`. That character is then delivered normally. A character with that bit at 0 leaves the receiver asleep.
- R13: After reset all five flags, `asleep`, `rxData` and `rxBit9` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling enable, 16 per bit time |
| rxLine | input | 1 | Serial receive line, idle high |
| nineBitMode | input | 1 | 1 selects 9 data bits per character |
| wakeByAddr | input | 1 | Wake method: 1 address mark, 0 idle line |
| sleepSet | input | 1 | Pulse that puts the receiver asleep |
| clearFlags | input | 1 | Pulse that clears the five status flags |
| rxData | output | 8 | Received character |
| rxBit9 | output | 1 | Ninth received bit |
| rxFull | output | 1 | Character waiting |
| idleFlag | output | 1 | Idle line seen |
| overrunFlag | output | 1 | Character lost to a full holding register |
| noiseFlag | output | 1 | Sample disagreement in the last character |
| frameErr | output | 1 | Stop bit sampled as 0 |
| asleep | output | 1 | Receiver sleeping |

## Verification
The bench drives the line one oversampling tick at a time, so it can flip chosen samples inside a bit. Clean characters with varied bit patterns in both widths show that bit order and ninth-bit placement are right. A single flipped mid-bit sample shows that noise is flagged without corrupting the data. Two flipped samples show that the vote, and not any one sample, decides the bit.

Start-bit glitches with one and with two high confirmation samples tell an accepted noisy start from a rejected false start. A low stop bit, back-to-back characters without a clear, timed idle stretches and sleeping sessions under both wake methods each isolate one flag or one wake path.

// File: rtl/nvrx_pkg.sv
package nvrx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic frameDone;
    logic stopBad;
    logic frameNoisy;
    logic idleSeen;
  } rxStrobe_t;
endpackage

// File: rtl/nvrx_ctrl.sv
module nvrx_ctrl
  import nvrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      rxLine,
  input  logic      nineBitMode,
  output rxStrobe_t strobe
);
  localparam int OSR    = 16;
  localparam int TICKS8 = (DATA_W + 2) * OSR;
  localparam int TICKS9 = (DATA_W + 3) * OSR;
  localparam int CNT_W  = $clog2(TICKS9 + 1);
  localparam int BIT_W  = $clog2(DATA_W + 1);

  rxState_t         state;
  logic [3:0]       phase;
  logic [BIT_W-1:0] bitIdx;
  logic [1:0]       smp;
  logic             noisyAcc;
  logic             rxPrev;
  logic [CNT_W-1:0] idleCnt;

  logic [2:0]       votes;
  logic             maj;
  logic             split;
  logic [CNT_W-1:0] charTicks;
  logic [BIT_W-1:0] lastIdx;

  // the two earlier samples of a vote are held; the third is the live line
  always_comb begin
    votes     = {smp, rxLine};
    maj       = ($countones(votes) >= 2);
    split     = (votes != 3'b000) && (votes != 3'b111);
    charTicks = nineBitMode ? CNT_W'(TICKS9) : CNT_W'(TICKS8);
    lastIdx   = nineBitMode ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);
  end

  always_comb begin
    strobe = '0;
    if (tick) begin
      case (state)
        ST_IDLE: strobe.idleSeen = rxLine && (idleCnt == charTicks - CNT_W'(1));
        ST_DATA: begin
          strobe.shiftEn  = (phase == 4'd10);
          strobe.shiftBit = maj;
        end
        ST_STOP: begin
          strobe.frameDone  = (phase == 4'd10);
          strobe.stopBad    = !maj;
          strobe.frameNoisy = noisyAcc | split;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= '0;
      bitIdx   <= '0;
      smp      <= '0;
      noisyAcc <= 1'b0;
      rxPrev   <= 1'b0;
      idleCnt  <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          rxPrev <= rxLine;
          if (!rxLine)                idleCnt <= '0;
          else if (idleCnt < charTicks) idleCnt <= idleCnt + CNT_W'(1);
          if (rxPrev && !rxLine) begin
            state    <= ST_START;
            phase    <= 4'd2;
            bitIdx   <= '0;
            noisyAcc <= 1'b0;
            idleCnt  <= '0;
          end
        end
        ST_START: begin
          phase <= phase + 4'd1;
          if (phase inside {4'd3, 4'd5}) smp <= {smp[0], rxLine};
          if (phase == 4'd7) begin
            if (maj) begin
              state  <= ST_IDLE;
              rxPrev <= rxLine;
            end else begin
              noisyAcc <= split;
            end
          end
          if (phase == 4'd0) state <= ST_DATA;
        end
        ST_DATA: begin
          phase <= phase + 4'd1;
          if (phase inside {4'd8, 4'd9}) smp <= {smp[0], rxLine};
          if (phase == 4'd10) noisyAcc <= noisyAcc | split;
          if (phase == 4'd0) begin
            if (bitIdx == lastIdx) state <= ST_STOP;
            else                   bitIdx <= bitIdx + BIT_W'(1);
          end
        end
        ST_STOP: begin
          phase <= phase + 4'd1;
          if (phase inside {4'd8, 4'd9}) smp <= {smp[0], rxLine};
          if (phase == 4'd10) begin
            state   <= ST_IDLE;
            rxPrev  <= maj;
            idleCnt <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // checker support: data bits shifted since the last start edge
  logic [BIT_W:0] shiftCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                                        shiftCnt <= '0;
    else if (tick && state == ST_IDLE && rxPrev && !rxLine) shiftCnt <= '0;
    else if (strobe.shiftEn)                          shiftCnt <= shiftCnt + (BIT_W+1)'(1);
  end

  AST_FRAME_BITS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameDone |-> shiftCnt == (nineBitMode ? (BIT_W+1)'(DATA_W + 1) : (BIT_W+1)'(DATA_W))); // R2
  AST_DONE_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameDone |-> !strobe.shiftEn && !strobe.idleSeen); // R1
endmodule

// File: rtl/nvrx_dp.sv
module nvrx_dp
  import nvrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic              nineBitMode,
  input  logic              wakeByAddr,
  input  logic              sleepSet,
  input  logic              clearFlags,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxFull,
  output logic              idleFlag,
  output logic              overrunFlag,
  output logic              noiseFlag,
  output logic              frameErr,
  output logic              asleep
);
  logic [DATA_W:0] shiftReg;
  logic            idleArmed;
  logic            addrWake;
  logic            idleWake;
  logic            takeFrame;

  // the last bit shifted in always lands in the top position, whatever the width
  always_comb begin
    addrWake  = strobe.frameDone && asleep && wakeByAddr && shiftReg[DATA_W];
    idleWake  = strobe.idleSeen && asleep && !wakeByAddr;
    takeFrame = strobe.frameDone && (!asleep || addrWake);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg    <= '0;
      rxData      <= '0;
      rxBit9      <= 1'b0;
      rxFull      <= 1'b0;
      idleFlag    <= 1'b0;
      overrunFlag <= 1'b0;
      noiseFlag   <= 1'b0;
      frameErr    <= 1'b0;
      idleArmed   <= 1'b0;
      asleep      <= 1'b0;
    end else begin
      if (strobe.shiftEn) shiftReg <= {strobe.shiftBit, shiftReg[DATA_W:1]};
      if (clearFlags) begin
        rxFull      <= 1'b0;
        idleFlag    <= 1'b0;
        overrunFlag <= 1'b0;
        noiseFlag   <= 1'b0;
        frameErr    <= 1'b0;
      end
      if (takeFrame) begin
        idleArmed <= 1'b1;
        if (rxFull) begin
          overrunFlag <= 1'b1;
        end else begin
          rxFull <= 1'b1;
          rxData <= nineBitMode ? shiftReg[DATA_W-1:0] : shiftReg[DATA_W:1];
          rxBit9 <= nineBitMode & shiftReg[DATA_W];
          if (strobe.stopBad)    frameErr  <= 1'b1;
          if (strobe.frameNoisy) noiseFlag <= 1'b1;
        end
      end
      if (strobe.idleSeen && !asleep && idleArmed) begin
        idleFlag  <= 1'b1;
        idleArmed <= 1'b0;
      end
      if (addrWake || idleWake) asleep <= 1'b0;
      else if (sleepSet)        asleep <= 1'b1;
    end
  end

  AST_KEEP_ON_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameDone && rxFull |=> $stable(rxData) && $stable(rxBit9)); // R7
  AST_ASLEEP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> !$past(asleep) || !asleep); // R10
  AST_IDLE_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleFlag) |-> !$past(asleep)); // R10
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    clearFlags && !strobe.frameDone && !strobe.idleSeen |=>
      !rxFull && !idleFlag && !overrunFlag && !noiseFlag && !frameErr); // R9
endmodule

// File: rtl/noise_vote_rx.sv
module noise_vote_rx
  import nvrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              rxLine,
  input  logic              nineBitMode,
  input  logic              wakeByAddr,
  input  logic              sleepSet,
  input  logic              clearFlags,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxFull,
  output logic              idleFlag,
  output logic              overrunFlag,
  output logic              noiseFlag,
  output logic              frameErr,
  output logic              asleep
);
  rxStrobe_t strobe;

  nvrx_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .rxLine(rxLine),
    .nineBitMode(nineBitMode), .strobe(strobe)
  );

  nvrx_dp #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .nineBitMode(nineBitMode),
    .wakeByAddr(wakeByAddr), .sleepSet(sleepSet), .clearFlags(clearFlags),
    .rxData(rxData), .rxBit9(rxBit9), .rxFull(rxFull), .idleFlag(idleFlag),
    .overrunFlag(overrunFlag), .noiseFlag(noiseFlag), .frameErr(frameErr),
    .asleep(asleep)
  );
endmodule

// File: tb/test_noise_vote_rx.sv
module test_noise_vote_rx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b1;
  logic       rxLine = 1'b1;
  logic       nineBitMode = 1'b0;
  logic       wakeByAddr = 1'b0;
  logic       sleepSet = 1'b0;
  logic       clearFlags = 1'b0;
  logic [7:0] rxData;
  logic       rxBit9, rxFull, idleFlag, overrunFlag, noiseFlag, frameErr, asleep;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  noise_vote_rx i_noise_vote_rx (
    .clk(clk), .rstN(rstN), .tick(tick), .rxLine(rxLine),
    .nineBitMode(nineBitMode), .wakeByAddr(wakeByAddr), .sleepSet(sleepSet),
    .clearFlags(clearFlags), .rxData(rxData), .rxBit9(rxBit9), .rxFull(rxFull),
    .idleFlag(idleFlag), .overrunFlag(overrunFlag), .noiseFlag(noiseFlag),
    .frameErr(frameErr), .asleep(asleep)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one bit = 16 ticks; mask bit k flips the line on tick k (tick k is phase k+1)
  task automatic sendBit(input logic v, input logic [15:0] mask);
    for (int k = 0; k < 16; k++) begin
      rxLine = v ^ mask[k];
      @(negedge clk);
    end
  endtask

  task automatic idleTicks(input int n);
    rxLine = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [8:0] d, input logic [15:0] startMask,
                           input int noisyBit, input logic [15:0] bitMask, input logic stopV);
    idleTicks(2);
    sendBit(1'b0, startMask);
    for (int i = 0; i < (nineBitMode ? 9 : 8); i++)
      sendBit(d[i], (i == noisyBit) ? bitMask : 16'h0000);
    sendBit(stopV, 16'h0000);
    rxLine = 1'b1;
  endtask

  task automatic plain(input logic [8:0] d);
    sendFrame(d, 16'h0000, -1, 16'h0000, 1'b1);
  endtask

  task automatic clearAll();
    clearFlags = 1'b1;
    @(negedge clk);
    clearFlags = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 rxFull", rxFull, 0);
    chk("R13 flags", {idleFlag, overrunFlag, noiseFlag, frameErr}, 0);
    chk("R13 asleep", asleep, 0);
    chk("R13 data", {rxBit9, rxData}, 0);
    idleTicks(300);
    chk("R8 no idle before first char", idleFlag, 0);
  endtask

  task automatic t_basic();
    logic [7:0] pats [3] = '{8'hA5, 8'h3C, 8'h01};
    for (int p = 0; p < 3; p++) begin
      clearAll();
      plain({1'b0, pats[p]});
      chk("R1 full", rxFull, 1);
      chk("R1 data", rxData, pats[p]);
      chk("R4 clean frame no noise", noiseFlag, 0);
      chk("R6 clean frame no error", frameErr, 0);
      chk("R2 bit9 zero in 8-bit", rxBit9, 0);
    end
    clearAll();
    chk("R9 full cleared", rxFull, 0);
  endtask

  task automatic t_nine();
    nineBitMode = 1'b1;
    clearAll();
    plain(9'h1C3);
    chk("R2 data", rxData, 8'hC3);
    chk("R2 ninth bit", rxBit9, 1);
    clearAll();
    plain(9'h03A);
    chk("R2 data b", rxData, 8'h3A);
    chk("R2 ninth bit b", rxBit9, 0);
    nineBitMode = 1'b0;
    clearAll();
  endtask

  task automatic t_noise();
    clearAll();
    sendFrame(9'h0F0, 16'h0000, 3, 16'h0100, 1'b1);
    chk("R4 one flipped sample data ok", rxData, 8'hF0);
    chk("R4 noise flagged", noiseFlag, 1);
    clearAll();
    sendFrame(9'h0F0, 16'h0000, 2, 16'h0180, 1'b1);
    chk("R3 majority flips bit", rxData, 8'hF4);
    chk("R3 noise flagged", noiseFlag, 1);
    clearAll();
  endtask

  task automatic t_start();
    clearAll();
    sendFrame(9'h055, 16'h0004, -1, 16'h0000, 1'b1);
    chk("R5 noisy start accepted", rxFull, 1);
    chk("R5 noisy start data", rxData, 8'h55);
    chk("R5 noisy start flag", noiseFlag, 1);
    clearAll();
    idleTicks(2);
    sendBit(1'b0, 16'h0014);
    idleTicks(200);
    chk("R5 false start dropped", rxFull, 0);
    chk("R5 false start no noise", noiseFlag, 0);
    clearAll();
  endtask

  task automatic t_frame();
    clearAll();
    sendFrame(9'h066, 16'h0000, -1, 16'h0000, 1'b0);
    idleTicks(4);
    chk("R6 frame error", frameErr, 1);
    chk("R6 data loaded", rxData, 8'h66);
    chk("R6 full set", rxFull, 1);
    clearAll();
  endtask

  task automatic t_overrun();
    clearAll();
    plain(9'h011);
    plain(9'h022);
    chk("R7 overrun", overrunFlag, 1);
    chk("R7 data kept", rxData, 8'h11);
    clearAll();
    chk("R9 all flags cleared", {rxFull, idleFlag, overrunFlag, noiseFlag, frameErr}, 0);
  endtask

  task automatic t_idle();
    clearAll();
    plain(9'h0C3);
    clearAll();
    idleTicks(100);
    chk("R8 idle not yet", idleFlag, 0);
    idleTicks(100);
    chk("R8 idle after char time", idleFlag, 1);
    clearAll();
    idleTicks(200);
    chk("R8 idle not re-armed", idleFlag, 0);
  endtask

  task automatic t_sleepAddr();
    wakeByAddr = 1'b1;
    clearAll();
    sleepSet = 1'b1; @(negedge clk); sleepSet = 1'b0;
    chk("R10 asleep", asleep, 1);
    plain(9'h012);
    chk("R10 asleep no full", rxFull, 0);
    chk("R12 still asleep", asleep, 1);
    plain(9'h085);
    chk("R12 woke on mark", asleep, 0);
    chk("R12 mark char full", rxFull, 1);
    chk("R12 mark char data", rxData, 8'h85);
    clearAll();
  endtask

  task automatic t_sleepIdle();
    wakeByAddr = 1'b0;
    clearAll();
    sleepSet = 1'b1; @(negedge clk); sleepSet = 1'b0;
    plain(9'h085);
    chk("R10 idle mode asleep no full", rxFull, 0);
    chk("R11 mark ignored in idle mode", asleep, 1);
    idleTicks(100);
    chk("R11 not yet awake", asleep, 1);
    idleTicks(100);
    chk("R11 woke on idle", asleep, 0);
    chk("R11 no idle flag", idleFlag, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_nine();
    t_noise();
    t_start();
    t_frame();
    t_overrun();
    t_idle();
    t_sleepAddr();
    t_sleepIdle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule